// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block keeps an 8-bit interrupt status register and an 8-bit enable mask, and raises one level-sensitive interrupt line. That line is high whenever any status bit is set while its mask bit is also set. Status bits are set by one-cycle event pulses from the rest of the controller. Two bits are also derived every cycle from the state of the transmit queues. The receive bit follows the receive queue when that queue is popped.

Software reads status at byte offset 0 and the mask at offset 1. A write to offset 0 acts as a write-one-to-clear acknowledge. Only the bits in 0xD6 can be cleared this way. Writing a one to bit 1 of the acknowledge also sends a pop strobe to the transmit-done queue. The strobe is sent only when that queue holds an entry. A write to offset 1 loads the mask.

The bit map is: bit 7 management, bit 6 early receive, bit 5 port status, bit 4 receive overrun, bit 3 allocation done, bit 2 transmit queue empty, bit 1 transmit complete, bit 0 receive.

Top module: `irq_stat_ctl`

## Requirements
- R1: After reset, status reads 0x04, the mask reads 0x00 and `irq` is low.
- R2: `irq` is high exactly when status AND mask is non-zero. A mask write changes `irq` from the next cycle, not in the cycle of the write.
- R3: A write to offset 0 clears only those status bits that are one in both the written value and 0xD6. Bits 5, 3 and 0 are never cleared by an acknowledge.
- R4: `txdone_pop` is high in the cycle of a write to offset 0 that has bit 1 set, and only when `txdone_cnt` is non-zero.
- R5: In every cycle where `txq_empty` is high, bit 2 is set at the next edge. An acknowledge of bit 2 in that cycle has no effect on it.
- R6: Bit 1 is set at the next edge whenever the transmit-done count, after any pop in this cycle, is non-zero. Acknowledging bit 1 with a count of 1 clears it. With a count of 2 it stays set.
- R7: On `rx_pop`, bit 0 takes the value of `rx_remain` (1 when entries remain in the receive queue).
- R8: A set pulse on `evt_set[k]` wins over an acknowledge clear or a receive pop of bit k in the same cycle.
- R9: `bus_rdata` returns status for `bus_addr` 0 and the mask for `bus_addr` 1, combinationally.
- R10: A write to offset 0 leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set | input | 8 | One-cycle set pulses, one per status bit |
| rx_pop | input | 1 | Receive queue entry removed this cycle |
| rx_remain | input | 1 | Receive queue still holds entries after the pop |
| txq_empty | input | 1 | Transmit queue is empty |
| txdone_cnt | input | CW | Entries in the transmit-done queue |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 1 | 0 selects status and acknowledge, 1 selects the mask |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data |
| txdone_pop | output | 1 | Pop strobe to the transmit-done queue |
| irq | output | 1 | Interrupt line |

## Verification
The assertions check the following on every cycle:
- set pulses land in status;
- acknowledges never touch bits outside 0xD6;
- the pop strobe never fires on an empty queue;
- the derived transmit bits follow their queue inputs;
- a zero mask keeps the line low.

Only the directed scenarios can show the other behaviours:
- the exact cycle in which a mask change reaches `irq`;
- bit 1 staying set or clearing depending on the count left after a pop;
- the receive bit following `rx_remain`;
- the mask surviving an acknowledge.

// File: rtl/irq_stat_ctl.sv
module irq_stat_ctl #(
  parameter int          CW       = 3,
  parameter logic [7:0]  ACK_OK   = 8'hD6,
  parameter logic [7:0]  RST_STAT = 8'h04
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    evt_set,
  input  logic          rx_pop,
  input  logic          rx_remain,
  input  logic          txq_empty,
  input  logic [CW-1:0] txdone_cnt,
  input  logic          bus_wr,
  input  logic          bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          txdone_pop,
  output logic          irq
);
  localparam int B_RX = 0;
  localparam int B_TX = 1;
  localparam int B_TE = 2;

  logic [7:0]    st, mk, st_nx;
  logic          ack;
  logic [CW-1:0] left_cnt;

  assign ack        = bus_wr && !bus_addr;
  assign txdone_pop = ack && bus_wdata[B_TX] && (txdone_cnt != '0);
  assign left_cnt   = txdone_cnt - CW'(txdone_pop);

  always_comb begin
    st_nx = st;
    if (ack) st_nx = st_nx & ~(bus_wdata & ACK_OK);
    if (rx_pop) st_nx[B_RX] = rx_remain;
    st_nx = st_nx | evt_set;
    if (txq_empty) st_nx[B_TE] = 1'b1;
    if (left_cnt != '0) st_nx[B_TX] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= RST_STAT;
      mk <= '0;
    end else begin
      st <= st_nx;
      if (bus_wr && bus_addr) mk <= bus_wdata;
    end
  end

  assign irq       = |(st & mk);
  assign bus_rdata = bus_addr ? mk : st;
endmodule

module irq_stat_chk #(
  parameter int         CW     = 3,
  parameter logic [7:0] ACK_OK = 8'hD6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    evt_set,
  input logic          rx_pop,
  input logic          txq_empty,
  input logic [CW-1:0] txdone_cnt,
  input logic          bus_wr,
  input logic          bus_addr,
  input logic [7:0]    bus_wdata,
  input logic          txdone_pop,
  input logic          irq,
  input logic [7:0]    st
);
  a_r8_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != 8'h00) |=> ((st & $past(evt_set)) == $past(evt_set)));

  a_r3_keep_unackable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr && !rx_pop) |=>
      ((st & $past(st) & ~ACK_OK) == ($past(st) & ~ACK_OK)));

  a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    txdone_pop |-> (txdone_cnt != '0));

  a_r4_pop_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    txdone_pop |-> (bus_wr && !bus_addr && bus_wdata[1]));

  a_r5_empty_bit: assert property (@(posedge clk) disable iff (!rst_n)
    txq_empty |=> st[2]);

  a_r6_done_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (txdone_cnt > CW'(1)) |=> st[1]);

  a_r2_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr && bus_wdata == 8'h00) |=> !irq);
endmodule

bind irq_stat_ctl irq_stat_chk #(.CW(CW), .ACK_OK(ACK_OK)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .rx_pop(rx_pop),
  .txq_empty(txq_empty), .txdone_cnt(txdone_cnt), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .txdone_pop(txdone_pop),
  .irq(irq), .st(st)
);

// File: tb/tb_irq_stat_ctl.sv
module tb_irq_stat_ctl;
  localparam int CW = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] evt_set = '0;
  logic rx_pop = 1'b0, rx_remain = 1'b0, txq_empty = 1'b0;
  logic [CW-1:0] txdone_cnt = '0;
  logic bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic txdone_pop, irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  irq_stat_ctl #(.CW(CW)) dut (.*);

  always #2 clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    evt_set = '0; rx_pop = 0; bus_wr = 0; bus_addr = 0; bus_wdata = '0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic rd(string req, logic a, logic [7:0] exp);
    bus_addr = a; #1;
    chk(req, bus_rdata, exp);
    bus_addr = 0;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic t_reset();
    rd("R1 status", 0, 8'h04);
    rd("R1 mask", 1, 8'h00);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_ack_limits();
    wr(0, 8'h04); step();
    rd("R5 ack bit2 when not empty", 0, 8'h00);
    evt_set = 8'hFF; step();
    rd("R8 all set", 0, 8'hFF);
    wr(0, 8'hFF); #1;
    chk("R4 no pop on empty queue", txdone_pop, 0);
    step();
    rd("R3 only 0xD6 cleared", 0, 8'h29);
  endtask

  task automatic t_rx();
    rx_pop = 1; rx_remain = 1; step();
    rd("R7 remain keeps bit0", 0, 8'h29);
    rx_pop = 1; rx_remain = 0; step();
    rd("R7 empty clears bit0", 0, 8'h28);
  endtask

  task automatic t_mask();
    wr(1, 8'h08); #1;
    chk("R2 irq not yet", irq, 0);
    step();
    chk("R2 irq after mask", irq, 1);
    rd("R9 mask read", 1, 8'h08);
    wr(1, 8'h10); step();
    chk("R2 irq masked off", irq, 0);
    wr(0, 8'h00); step();
    rd("R10 mask kept", 1, 8'h10);
  endtask

  task automatic t_txempty();
    txq_empty = 1; step();
    rd("R5 set while empty", 0, 8'h2C);
    wr(0, 8'h04); step();
    rd("R5 ack ignored while empty", 0, 8'h2C);
    txq_empty = 0; wr(0, 8'h04); step();
    rd("R5 ack clears", 0, 8'h28);
  endtask

  task automatic t_txdone();
    txdone_cnt = 2; step();
    rd("R6 set by count", 0, 8'h2A);
    wr(0, 8'h02); #1;
    chk("R4 pop with 2", txdone_pop, 1);
    step();
    rd("R6 stays with 1 left", 0, 8'h2A);
    txdone_cnt = 1; wr(0, 8'h02); #1;
    chk("R4 pop with 1", txdone_pop, 1);
    step();
    txdone_cnt = 0;
    rd("R6 cleared with 0 left", 0, 8'h28);
    wr(0, 8'h02); #1;
    chk("R4 no pop at 0", txdone_pop, 0);
    step();
  endtask

  task automatic t_priority();
    evt_set = 8'h10; wr(0, 8'h10); step();
    rd("R8 set beats ack", 0, 8'h38);
    chk("R2 irq on", irq, 1);
    wr(0, 8'h10); step();
    rd("R3 ack bit4", 0, 8'h28);
    chk("R2 irq off", irq, 0);
    evt_set = 8'h01; rx_pop = 1; rx_remain = 0; step();
    rd("R8 set beats rx pop", 0, 8'h29);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ack_limits();
    t_rx();
    t_mask();
    t_txempty();
    t_txdone();
    t_priority();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule